// File: doc/BRIEF.md
# Configurable Split Up-Counting Timer

This block is a timer core built on one free-running up-counter whose width is twice a parameterised half width. Software picks one of three arrangements through a control register. The whole counter can run as a single wide timer. It can also run as two halves, where the low half acts as a prescaler that advances the high half. Finally, the two halves can count on their own. Each half compares itself against its own period register and raises a sticky, level-type period interrupt.

A bank of compare registers watches the low half of the counter and produces one-cycle interrupt pulses, one line per channel. The timer only advances on cycles where the timer clock enable input is high, so a slower tick can be derived from the system clock outside the block. All configuration and status go through a simple synchronous write port and a combinational read port.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads zero (control, both counter halves, both periods, status and all compare values) and every interrupt output is low.
- R2: The counter changes only on clock edges where `tick_en` is high and the relevant enable bit is set, or when a software clear is written. Enable bits: control bit 2 for the low half, control bit 3 for the high half.
- R3: With control bits [1:0] = 0 (wide mode), the full counter {high, low} counts up by one per tick while bit 2 is set, and a carry out of the low half increments the high half.
- R4: In wide mode, a tick that finds the full counter equal to {period_hi, period_lo} loads zero and sets status bit 0; `irq_hi` stays low.
- R5: With control bits [1:0] = 1 (chained mode), the low half wraps from period_lo to zero and sets status bit 0. Each such wrap advances the high half when bit 3 is set, and the high half wraps from period_hi to zero and sets status bit 1.
- R6: With control bits [1:0] = 2 (independent mode), each half counts on its own tick and enable, wraps from its own period to zero and sets its own status bit (0 for low, 1 for high).
- R7: Writing control bit 4 (low) or bit 5 (high) as one clears that half on that clock edge and leaves the other half untouched. These two bits are not stored and read back as zero.
- R8: Status bits are sticky and cleared by writing one to them; a written zero leaves a bit unchanged. `irq_lo` follows status bit 0 and `irq_hi` follows status bit 1.
- R9: For compare channel i with control bit 8+i set, a tick during which the low counter equals compare register i makes `irq_cmp[i]` high for exactly the next cycle and sets status bit 2+i.
- R10: A compare channel whose enable bit is clear never pulses and never sets its status bit.
- R11: Register addresses are: 0 control, 1 counter low, 2 counter high, 3 period low, 4 period high, 5 status, 8+i compare i. Written period and compare values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable; counters advance only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | HALF_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | HALF_W | Combinational read data |
| irq_lo | output | 1 | Low-half (or wide) period interrupt, level |
| irq_hi | output | 1 | High-half period interrupt, level |
| irq_cmp | output | NUM_CMP | Compare interrupt pulses, one per channel |

## Verification
The wide mode is swept tick by tick across a period larger than the low half. This shows the carry into the high half and the exact wrap cycle, and it separates an off-by-one period from a missing carry. Chained and independent modes are each swept over several periods with small, coprime period values. Because of that, a swapped or shared period, or a high half that steps on every tick instead of on low wraps, gives visibly different counts. A gated tick pattern tells tick gating apart from free counting. The compare sweep uses distinct values with one channel disabled, which exposes wrong channel order, wrong pulse timing and a broken enable mask.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE  = 2'd0,
        MODE_CHAIN = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_RSVD  = 2'd3
    } tmode_e;

    typedef struct packed {
        tmode_e mode;
        logic   en_lo;
        logic   en_hi;
    } tctrl_t;

    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_CNT_LO = 1;
    localparam int unsigned A_CNT_HI = 2;
    localparam int unsigned A_PRD_LO = 3;
    localparam int unsigned A_PRD_HI = 4;
    localparam int unsigned A_STAT   = 5;
    localparam int unsigned A_CMP0   = 8;

    localparam int unsigned B_EN_LO  = 2;
    localparam int unsigned B_EN_HI  = 3;
    localparam int unsigned B_CLR_LO = 4;
    localparam int unsigned B_CLR_HI = 5;
    localparam int unsigned B_CMP_EN = 8;

endpackage

// File: rtl/st_count.sv
module st_count
    import split_timer_pkg::*;
#(
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tctrl_t            ctrl,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic [HALF_W-1:0] prd_lo,
    input  logic [HALF_W-1:0] prd_hi,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic              hit_lo,
    output logic              hit_hi
);
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};
    localparam logic [FULL_W-1:0] ONE_F = {{(FULL_W-1){1'b0}}, 1'b1};

    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic [FULL_W-1:0] full_nxt;
    logic              step_lo, step_hi;

    always_comb begin
        nxt_lo   = cnt_lo;
        nxt_hi   = cnt_hi;
        hit_lo   = 1'b0;
        hit_hi   = 1'b0;
        full_nxt = {cnt_hi, cnt_lo} + ONE_F;
        step_lo  = tick & ctrl.en_lo;
        step_hi  = tick & ctrl.en_hi;
        case (ctrl.mode)
            MODE_WIDE: begin
                if (step_lo) begin
                    if ({cnt_hi, cnt_lo} == {prd_hi, prd_lo}) begin
                        nxt_lo = '0;
                        nxt_hi = '0;
                        hit_lo = 1'b1;
                    end else begin
                        {nxt_hi, nxt_lo} = full_nxt;
                    end
                end
            end
            MODE_CHAIN: begin
                if (step_lo) begin
                    if (cnt_lo == prd_lo) begin
                        nxt_lo = '0;
                        hit_lo = 1'b1;
                        if (ctrl.en_hi) begin
                            if (cnt_hi == prd_hi) begin
                                nxt_hi = '0;
                                hit_hi = 1'b1;
                            end else begin
                                nxt_hi = cnt_hi + ONE_H;
                            end
                        end
                    end else begin
                        nxt_lo = cnt_lo + ONE_H;
                    end
                end
            end
            default: begin
                if (step_lo) begin
                    if (cnt_lo == prd_lo) begin
                        nxt_lo = '0;
                        hit_lo = 1'b1;
                    end else begin
                        nxt_lo = cnt_lo + ONE_H;
                    end
                end
                if (step_hi) begin
                    if (cnt_hi == prd_hi) begin
                        nxt_hi = '0;
                        hit_hi = 1'b1;
                    end else begin
                        nxt_hi = cnt_hi + ONE_H;
                    end
                end
            end
        endcase
        if (clr_lo) nxt_lo = '0;
        if (clr_hi) nxt_hi = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
        end
    end

endmodule

// File: rtl/st_cmp.sv
module st_cmp #(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned NUM_CMP = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick,
    input  logic [HALF_W-1:0]              cnt_lo,
    input  logic [NUM_CMP-1:0]             cmp_en,
    input  logic [NUM_CMP-1:0][HALF_W-1:0] cmp_val,
    output logic [NUM_CMP-1:0]             cmp_hit
);
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_hit[g] <= 1'b0;
            end else begin
                cmp_hit[g] <= tick & cmp_en[g] & (cnt_lo == cmp_val[g]);
            end
        end
    end

endmodule

// File: rtl/st_regs.sv
module st_regs
    import split_timer_pkg::*;
#(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned NUM_CMP = 8,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [HALF_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [HALF_W-1:0]              rd_data,
    input  logic                           hit_lo,
    input  logic                           hit_hi,
    input  logic [NUM_CMP-1:0]             cmp_hit,
    input  logic [HALF_W-1:0]              cnt_lo,
    input  logic [HALF_W-1:0]              cnt_hi,
    output tctrl_t                         ctrl,
    output logic [NUM_CMP-1:0]             cmp_en,
    output logic                           clr_lo,
    output logic                           clr_hi,
    output logic [HALF_W-1:0]              prd_lo,
    output logic [HALF_W-1:0]              prd_hi,
    output logic [NUM_CMP-1:0][HALF_W-1:0] cmp_val,
    output logic [NUM_CMP+1:0]             stat
);
    localparam int unsigned STAT_W = NUM_CMP + 2;

    logic wr_ctrl, wr_stat;
    logic [STAT_W-1:0] stat_clr, stat_set;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
    assign wr_stat  = wr_en && (wr_addr == ADDR_W'(A_STAT));
    assign clr_lo   = wr_ctrl && wr_data[B_CLR_LO];
    assign clr_hi   = wr_ctrl && wr_data[B_CLR_HI];
    assign stat_clr = wr_stat ? wr_data[STAT_W-1:0] : '0;
    assign stat_set = {cmp_hit, hit_hi, hit_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            cmp_en  <= '0;
            prd_lo  <= '0;
            prd_hi  <= '0;
            cmp_val <= '0;
            stat    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.mode  <= tmode_e'(wr_data[1:0]);
                ctrl.en_lo <= wr_data[B_EN_LO];
                ctrl.en_hi <= wr_data[B_EN_HI];
                cmp_en     <= wr_data[B_CMP_EN +: NUM_CMP];
            end
            if (wr_en && (wr_addr == ADDR_W'(A_PRD_LO))) prd_lo <= wr_data;
            if (wr_en && (wr_addr == ADDR_W'(A_PRD_HI))) prd_hi <= wr_data;
            for (int i = 0; i < NUM_CMP; i++) begin
                if (wr_en && (wr_addr == ADDR_W'(A_CMP0 + i))) cmp_val[i] <= wr_data;
            end
            stat <= (stat & ~stat_clr) | stat_set;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL):   rd_data = HALF_W'({cmp_en, 4'b0000, ctrl.en_hi, ctrl.en_lo, ctrl.mode});
            ADDR_W'(A_CNT_LO): rd_data = cnt_lo;
            ADDR_W'(A_CNT_HI): rd_data = cnt_hi;
            ADDR_W'(A_PRD_LO): rd_data = prd_lo;
            ADDR_W'(A_PRD_HI): rd_data = prd_hi;
            ADDR_W'(A_STAT):   rd_data = HALF_W'(stat);
            default: begin
                for (int i = 0; i < NUM_CMP; i++) begin
                    if (rd_addr == ADDR_W'(A_CMP0 + i)) rd_data = cmp_val[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
#(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned NUM_CMP = 8,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [HALF_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [HALF_W-1:0]  rd_data,
    output logic               irq_lo,
    output logic               irq_hi,
    output logic [NUM_CMP-1:0] irq_cmp
);
    tctrl_t                         ctrl;
    logic [NUM_CMP-1:0]             cmp_en;
    logic                           clr_lo, clr_hi;
    logic [HALF_W-1:0]              prd_lo, prd_hi;
    logic [HALF_W-1:0]              cnt_lo, cnt_hi;
    logic [NUM_CMP-1:0][HALF_W-1:0] cmp_val;
    logic [NUM_CMP+1:0]             stat;
    logic                           hit_lo, hit_hi;
    logic [NUM_CMP-1:0]             cmp_hit;

    st_regs #(.HALF_W(HALF_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hit_lo(hit_lo), .hit_hi(hit_hi),
        .cmp_hit(cmp_hit), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ctrl(ctrl),
        .cmp_en(cmp_en), .clr_lo(clr_lo), .clr_hi(clr_hi), .prd_lo(prd_lo),
        .prd_hi(prd_hi), .cmp_val(cmp_val), .stat(stat)
    );

    st_count #(.HALF_W(HALF_W)) u_count (
        .clk(clk), .rst(rst), .tick(tick_en), .ctrl(ctrl), .clr_lo(clr_lo),
        .clr_hi(clr_hi), .prd_lo(prd_lo), .prd_hi(prd_hi), .cnt_lo(cnt_lo),
        .cnt_hi(cnt_hi), .hit_lo(hit_lo), .hit_hi(hit_hi)
    );

    st_cmp #(.HALF_W(HALF_W), .NUM_CMP(NUM_CMP)) u_cmp (
        .clk(clk), .rst(rst), .tick(tick_en), .cnt_lo(cnt_lo), .cmp_en(cmp_en),
        .cmp_val(cmp_val), .cmp_hit(cmp_hit)
    );

    assign irq_lo  = stat[0];
    assign irq_hi  = stat[1];
    assign irq_cmp = cmp_hit;

endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk #(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned NUM_CMP = 8,
    parameter int unsigned ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               wd_bit0,
    input logic               wd_clr_lo,
    input logic               wd_clr_hi,
    input logic [HALF_W-1:0]  cnt_lo,
    input logic [HALF_W-1:0]  cnt_hi,
    input logic               irq_lo,
    input logic [NUM_CMP-1:0] irq_cmp
);
    logic ctrl_wr, stat_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(0));
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(5));

    // R2: without a tick and without a clear the counter holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !(ctrl_wr && (wd_clr_lo || wd_clr_hi)))
            |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R7: a low-half clear lands on the next edge
    a_r7_clear_lo: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wd_clr_lo) |=> (cnt_lo == '0));

    // R7: a high-half clear lands on the next edge
    a_r7_clear_hi: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wd_clr_hi) |=> (cnt_hi == '0));

    // R8: period status stays until written one
    a_r8_sticky_lo: assert property (@(posedge clk) disable iff (rst)
        (irq_lo && !(stat_wr && wd_bit0)) |=> irq_lo);

    // R4: a period interrupt only rises after a tick
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_lo) |-> $past(tick_en));

    // R9: a compare pulse always follows a tick
    a_r9_cmp_after_tick: assert property (@(posedge clk) disable iff (rst)
        (|irq_cmp) |-> $past(tick_en));

endmodule

bind split_timer split_timer_chk #(.HALF_W(HALF_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wd_bit0(wr_data[0]), .wd_clr_lo(wr_data[4]), .wd_clr_hi(wr_data[5]),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_cmp(irq_cmp)
);

// File: tb/sim_split_timer.sv
`timescale 1ns/1ps
module sim_split_timer;
    localparam int HW = 16;
    localparam int NC = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [HW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [HW-1:0] rd_data;
    logic          irq_lo, irq_hi;
    logic [NC-1:0] irq_cmp;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    split_timer #(.HALF_W(HW), .NUM_CMP(NC), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo),
        .irq_hi(irq_hi), .irq_cmp(irq_cmp)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [HW-1:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [HW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic step(input logic t);
        tick_en = t;
        @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic rd_cnt(output logic [HW-1:0] lo, output logic [HW-1:0] hi);
        rd(4'd1, lo);
        rd(4'd2, hi);
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [HW-1:0] lo, hi, v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            if (a < 6 || a >= 8) begin
                rd(a[AW-1:0], v);
                chk("R1 reset register", {16'h0, v}, 32'h0);
            end
        end
        chk("R1 reset irqs", {22'h0, irq_cmp, irq_hi, irq_lo}, 32'h0);

        // R3/R4: wide mode, period {1,5} = 65541
        wr(4'd3, 16'h0005);
        wr(4'd4, 16'h0001);
        wr(4'd0, 16'h0004);
        for (int k = 1; k <= 65542; k++) begin
            step(1'b1);
            rd_cnt(lo, hi);
            chk("R3 wide count", {hi, lo}, (k == 65542) ? 32'h0 : 32'(k));
            chk("R4 wide period irq", {31'h0, irq_lo}, {31'h0, k == 65542});
        end
        chk("R4 wide irq_hi low", {31'h0, irq_hi}, 32'h0);

        // R8: writing zero keeps status, writing one clears it
        wr(4'd5, 16'h0000);
        chk("R8 write zero keeps", {31'h0, irq_lo}, 32'h1);
        wr(4'd5, 16'h0001);
        chk("R8 write one clears", {31'h0, irq_lo}, 32'h0);

        // R2: gated tick pattern, one tick in three
        for (int i = 0; i < 30; i++) step(i % 3 == 0);
        rd_cnt(lo, hi);
        chk("R2 gated ticks", {hi, lo}, 32'd10);
        wr(4'd0, 16'h0000);
        for (int i = 0; i < 5; i++) step(1'b1);
        rd_cnt(lo, hi);
        chk("R2 enable off holds", {hi, lo}, 32'd10);

        // R7: clear both halves; clear bits read back zero
        wr(4'd0, 16'h0030);
        rd_cnt(lo, hi);
        chk("R7 clear both", {hi, lo}, 32'h0);
        rd(4'd0, v);
        chk("R7 clear bits not stored", {16'h0, v}, 32'h0);

        // R5: chained, low period 3, high period 2
        wr(4'd3, 16'd3);
        wr(4'd4, 16'd2);
        wr(4'd0, 16'h000D);
        for (int n = 1; n <= 12; n++) begin
            step(1'b1);
            rd_cnt(lo, hi);
            chk("R5 chained low", {16'h0, lo}, 32'(n % 4));
            chk("R5 chained high", {16'h0, hi}, 32'((n / 4) % 3));
            chk("R5 chained irqs", {30'h0, irq_hi, irq_lo}, {30'h0, n >= 12, n >= 4});
        end
        wr(4'd5, 16'h0003);
        chk("R8 clear both", {30'h0, irq_hi, irq_lo}, 32'h0);

        // R6: independent, periods 4 and 6
        wr(4'd0, 16'h0030);
        wr(4'd3, 16'd4);
        wr(4'd4, 16'd6);
        wr(4'd0, 16'h000E);
        for (int n = 1; n <= 40; n++) begin
            step(1'b1);
            rd_cnt(lo, hi);
            chk("R6 split low", {16'h0, lo}, 32'(n % 5));
            chk("R6 split high", {16'h0, hi}, 32'(n % 7));
            chk("R6 split irqs", {30'h0, irq_hi, irq_lo}, {30'h0, n >= 7, n >= 5});
        end
        wr(4'd0, 16'h0006);
        for (int i = 0; i < 3; i++) step(1'b1);
        rd_cnt(lo, hi);
        chk("R6 low on own enable", {16'h0, lo}, 32'd3);
        chk("R6 high disabled holds", {16'h0, hi}, 32'd5);

        // R7: low clear leaves high
        wr(4'd0, 16'h0016);
        rd_cnt(lo, hi);
        chk("R7 low cleared", {16'h0, lo}, 32'h0);
        chk("R7 high untouched", {16'h0, hi}, 32'd5);
        rd(4'd0, v);
        chk("R7 ctrl readback", {16'h0, v}, 32'h0006);

        // R9/R10/R11: compare bank, channel 3 disabled
        wr(4'd5, 16'hFFFF);
        wr(4'd3, 16'hFFFF);
        for (int i = 0; i < NC; i++) wr(4'(8 + i), 16'(10 + i));
        wr(4'd0, 16'hF716);
        for (int k = 1; k <= 25; k++) begin
            logic [NC-1:0] m;
            step(1'b1);
            m = '0;
            for (int i = 0; i < NC; i++) if (k == 11 + i && i != 3) m[i] = 1'b1;
            chk((k == 14) ? "R10 disabled channel" : "R9 compare pulse", {24'h0, irq_cmp}, {24'h0, m});
        end
        rd(4'd5, v);
        chk("R9 R10 compare status", {16'h0, v}, 32'h03DC);
        rd(4'd3, v);
        chk("R11 period readback", {16'h0, v}, 32'hFFFF);
        rd(4'd13, v);
        chk("R11 compare readback", {16'h0, v}, 32'd15);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule